// File: doc/BRIEF.md
# Host Bus Register Bridge

This block is the slave end of an asynchronous parallel bus driven by a host processor. The host sees only a couple of bus addresses. One is an index register. The other is a data port that reads or writes the internal register selected by the index, then advances the index. The host strobes are active low and are not timed by the engine clock. Each strobe goes through a synchroniser, and every strobe pulse becomes exactly one internal transfer in the engine clock domain. A read result is placed on the bus output inside the minimum strobe width.

The bus is either 16 bits wide with a 4-bit address or 8 bits wide with a 3-bit address, selected by a static input. When the camera function is switched off, the block hands the LCD control pins straight to the host. In that mode the host's second chip select, its address bit 0, its write strobe and its data bus drive the LCD pins with no clock in the path. When the camera function is on, an internal display controller owns those pins.

Top module: `hostbus_bridge`

## Requirements
- R1: After reset the index is 0, every internal register holds 0, the bus output word is 0 and the output enable is low.
- R2: A write to address 0 loads the index from the low index bits of the write data, and the index does not then advance. A read of address 0 returns the index zero-extended and leaves the index unchanged.
- R3: A write to address 1 stores the data in the register the index selects, then adds one to the index. The index wraps from the last register to 0.
- R4: A read of address 1 returns the register the index selects, then adds one to the index with the same wrap.
- R5: A read result is on `hdout` after the third rising clock edge that follows the fall of `hrd_n`. This is inside a read pulse of 4 engine cycles.
- R6: A strobe pulse causes exactly one transfer however long it stays low. A read pulse of 20 cycles on address 1 advances the index by one.
- R7: When `bus_wide` is 0, only address bits 2:0 are decoded, so address 9 acts as address 1. Writes store the low data byte zero-extended, and reads return the upper byte as 0. When `bus_wide` is 1, all 4 address bits are decoded. Addresses other than 0 and 1 then ignore writes, return 0 on reads and leave the index unchanged.
- R8: `hdoe` is high only while `hcs1_n` and `hrd_n` are both low.
- R9: A strobe while `hcs1_n` is high has no effect on the registers or the index.
- R10: While `cam_en` is 0, `lcd_cs_n`, `lcd_rs`, `lcd_wr_n` and `lcd_data` follow `hcs2_n`, `haddr[0]`, `hwr_n` and `hdin` combinationally.
- R11: While `cam_en` is 1, the LCD pins follow the `core_lcd_*` inputs from the internal display controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_en | input | 1 | Camera function on; 0 selects LCD bypass |
| bus_wide | input | 1 | 1: 16-bit data with 4-bit address; 0: 8-bit data with 3-bit address |
| hcs1_n | input | 1 | Host chip select for the register interface, active low |
| hcs2_n | input | 1 | Host second chip select, passed to the LCD in bypass |
| haddr | input | 4 | Host address |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| hdin | input | 16 | Host write data |
| hdout | output | 16 | Read data toward the host |
| hdoe | output | 1 | Output enable for the host data bus |
| core_lcd_cs_n | input | 1 | LCD chip select from the internal display controller |
| core_lcd_rs | input | 1 | LCD register select from the internal display controller |
| core_lcd_wr_n | input | 1 | LCD write strobe from the internal display controller |
| core_lcd_data | input | 16 | LCD data from the internal display controller |
| lcd_cs_n | output | 1 | LCD chip select pin |
| lcd_rs | output | 1 | LCD register select pin |
| lcd_wr_n | output | 1 | LCD write strobe pin |
| lcd_data | output | 16 | LCD data pins |

## Verification
A read result reaches `hdout` three rising edges after `hrd_n` falls: two synchroniser flops and then the output register. The bench drives strobes on falling clock edges, waits for exactly three rising edges, and hands the expected word to the scoreboard monitor 2 ns later. Writes are then confirmed through later reads, each compared against a bench model of the index and registers. `hdoe` and the bypass pins have no register in their path, so they are checked 1 ns after the inputs move.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int NARROW_W = 8;

    typedef enum logic [1:0] {
        PORT_INDEX = 2'd0,
        PORT_DATA  = 2'd1,
        PORT_NONE  = 2'd2
    } port_e;

    typedef struct packed {
        logic vld;
        logic wr;
        logic wide;
    } xfer_ctl_t;

    function automatic port_e decode_port(input int unsigned eff);
        case (eff)
            0:       return PORT_INDEX;
            1:       return PORT_DATA;
            default: return PORT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hb_strobe_sync.sv
module hb_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its history
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], strobe_n};
    end

    assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/hb_regport.sv
module hb_regport
    import hb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  index,
    output logic              data_step
);
    logic [DATA_W-1:0] regs [NREG];
    logic [ADDR_W-1:0] eff_addr;
    port_e             port;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] sel_val;

    function automatic logic [DATA_W-1:0] low_byte(input logic [DATA_W-1:0] v);
        return {{(DATA_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
    endfunction

    always_comb begin
        eff_addr = ctl.wide ? addr : {1'b0, addr[ADDR_W-2:0]};
        port     = decode_port(int'(eff_addr));
        wr_val   = ctl.wide ? wdata : low_byte(wdata);
        sel_val  = ctl.wide ? regs[index] : low_byte(regs[index]);
    end

    assign data_step = ctl.vld && (port == PORT_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            index <= '0;
            rdata <= '0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (ctl.vld) begin
            case (port)
                PORT_INDEX: begin
                    if (ctl.wr) index <= wdata[IDX_W-1:0];
                    else        rdata <= DATA_W'(index);
                end
                PORT_DATA: begin
                    if (ctl.wr) regs[index] <= wr_val;
                    else        rdata       <= sel_val;
                    index <= index + 1'b1;
                end
                default: begin
                    if (!ctl.wr) rdata <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/hb_lcd_mux.sv
module hb_lcd_mux #(
    parameter int DATA_W = 16
) (
    input  logic              bypass,
    input  logic              host_cs_n,
    input  logic              host_rs,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              core_cs_n,
    input  logic              core_rs,
    input  logic              core_wr_n,
    input  logic [DATA_W-1:0] core_data,
    output logic              lcd_cs_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data
);
    always_comb begin
        if (bypass) begin
            lcd_cs_n = host_cs_n;
            lcd_rs   = host_rs;
            lcd_wr_n = host_wr_n;
            lcd_data = host_data;
        end else begin
            lcd_cs_n = core_cs_n;
            lcd_rs   = core_rs;
            lcd_wr_n = core_wr_n;
            lcd_data = core_data;
        end
    end
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
    import hb_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cam_en,
    input  logic              bus_wide,
    input  logic              hcs1_n,
    input  logic              hcs2_n,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hrd_n,
    input  logic              hwr_n,
    input  logic [DATA_W-1:0] hdin,
    output logic [DATA_W-1:0] hdout,
    output logic              hdoe,
    input  logic              core_lcd_cs_n,
    input  logic              core_lcd_rs,
    input  logic              core_lcd_wr_n,
    input  logic [DATA_W-1:0] core_lcd_data,
    output logic              lcd_cs_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data
);
    localparam int IDX_W = $clog2(NREG);

    logic             rd_fall;
    logic             wr_fall;
    xfer_ctl_t        ctl;
    logic [IDX_W-1:0] cur_index;
    logic             data_step;

    hb_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strobe_n(hrd_n), .fall(rd_fall)
    );

    hb_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strobe_n(hwr_n), .fall(wr_fall)
    );

    // Address and chip select are sampled in the cycle the strobe edge is seen
    always_comb begin
        ctl.vld  = (rd_fall || wr_fall) && !hcs1_n;
        ctl.wr   = wr_fall;
        ctl.wide = bus_wide;
    end

    hb_regport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_regport (
        .clk(clk), .rst(rst), .ctl(ctl), .addr(haddr), .wdata(hdin),
        .rdata(hdout), .index(cur_index), .data_step(data_step)
    );

    assign hdoe = !hcs1_n && !hrd_n;

    hb_lcd_mux #(.DATA_W(DATA_W)) u_lcd_mux (
        .bypass(!cam_en),
        .host_cs_n(hcs2_n), .host_rs(haddr[0]), .host_wr_n(hwr_n), .host_data(hdin),
        .core_cs_n(core_lcd_cs_n), .core_rs(core_lcd_rs),
        .core_wr_n(core_lcd_wr_n), .core_data(core_lcd_data),
        .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data)
    );
endmodule

// File: rtl/hostbus_bridge_chk.sv
module hostbus_bridge_chk #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              hrd_n,
    input logic              hcs1_n,
    input logic              hdoe,
    input logic [DATA_W-1:0] hdout,
    input logic              rd_fall,
    input logic              wr_fall,
    input logic [IDX_W-1:0]  cur_index,
    input logic              data_step
);
    // R8: the bus is released whenever the strobe or the chip select is inactive
    p_bus_released_r8: assert property (@(posedge clk) disable iff (rst)
        (hrd_n || hcs1_n) |-> !hdoe);

    // R6: one strobe pulse never yields back-to-back transfers
    p_single_read_r6: assert property (@(posedge clk) disable iff (rst)
        rd_fall |=> !rd_fall);
    p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr_fall |=> !wr_fall);

    // R5: read output word only moves after a recognised read
    p_dout_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_fall |=> $stable(hdout));

    // R3 / R4: a data-port access advances the index by one with wrap
    p_index_step_r3: assert property (@(posedge clk) disable iff (rst)
        data_step |=> cur_index == IDX_W'($past(cur_index) + 1'b1));

    // R9: without any strobe edge the index holds
    p_index_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(rd_fall || wr_fall) |=> $stable(cur_index));
endmodule

bind hostbus_bridge hostbus_bridge_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .hrd_n(hrd_n), .hcs1_n(hcs1_n), .hdoe(hdoe),
    .hdout(hdout), .rd_fall(rd_fall), .wr_fall(wr_fall),
    .cur_index(cur_index), .data_step(data_step)
);

// File: tb/hostbus_bridge_bench.sv
module hostbus_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cam_en = 1'b1;
    logic        bus_wide = 1'b1;
    logic        hcs1_n = 1'b1;
    logic        hcs2_n = 1'b1;
    logic [3:0]  haddr = '0;
    logic        hrd_n = 1'b1;
    logic        hwr_n = 1'b1;
    logic [15:0] hdin = '0;
    logic [15:0] hdout;
    logic        hdoe;
    logic        core_lcd_cs_n = 1'b1;
    logic        core_lcd_rs = 1'b0;
    logic        core_lcd_wr_n = 1'b1;
    logic [15:0] core_lcd_data = 16'h0F0F;
    logic        lcd_cs_n, lcd_rs, lcd_wr_n;
    logic [15:0] lcd_data;

    always #4 clk = ~clk;

    hostbus_bridge u_hostbus_bridge (
        .clk(clk), .rst(rst), .cam_en(cam_en), .bus_wide(bus_wide),
        .hcs1_n(hcs1_n), .hcs2_n(hcs2_n), .haddr(haddr), .hrd_n(hrd_n),
        .hwr_n(hwr_n), .hdin(hdin), .hdout(hdout), .hdoe(hdoe),
        .core_lcd_cs_n(core_lcd_cs_n), .core_lcd_rs(core_lcd_rs),
        .core_lcd_wr_n(core_lcd_wr_n), .core_lcd_data(core_lcd_data),
        .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t exp_q[$];
    event mon_ev;

    // Bench model of the index and registers
    logic [15:0] m_regs [16];
    logic [3:0]  m_idx;

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] eff(input logic [3:0] a);
        return bus_wide ? a : {1'b0, a[2:0]};
    endfunction

    task automatic host_write(input logic [3:0] a, input logic [15:0] d, input logic cs_n);
        if (!cs_n) begin
            if (eff(a) == 4'd0) m_idx = d[3:0];
            else if (eff(a) == 4'd1) begin
                m_regs[m_idx] = bus_wide ? d : {8'h00, d[7:0]};
                m_idx = m_idx + 1'b1;
            end
        end
        @(negedge clk); haddr = a; hdin = d; hcs1_n = cs_n;
        @(negedge clk); hwr_n = 1'b0;
        #1 check({15'b0, hdoe}, 16'h0, "R8 write");
        repeat (5) @(negedge clk);
        hwr_n = 1'b1;
        @(negedge clk); hcs1_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic host_read(input logic [3:0] a, input int hold, input string req);
        exp_t e;
        e.req = req;
        if (eff(a) == 4'd0) e.val = {12'h000, m_idx};
        else if (eff(a) == 4'd1) begin
            e.val = bus_wide ? m_regs[m_idx] : {8'h00, m_regs[m_idx][7:0]};
            m_idx = m_idx + 1'b1;
        end else e.val = 16'h0000;
        exp_q.push_back(e);
        @(negedge clk); haddr = a; hcs1_n = 1'b0;
        @(negedge clk); hrd_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check({15'b0, hdoe}, 16'h1, "R8 read active");
        ->mon_ev;                                   // R5 sample point
        repeat (hold) @(negedge clk);
        hrd_n = 1'b1;
        #1 check({15'b0, hdoe}, 16'h0, "R8 strobe high");
        @(negedge clk); hcs1_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            exp_t e;
            @(mon_ev);
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL scoreboard: actual %h expected <none>", hdout);
            end else begin
                e = exp_q.pop_front();
                check(hdout, e.val, e.req);
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_regs[i] = '0;
        m_idx = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        check(hdout, 16'h0, "R1 dout");
        check({15'b0, hdoe}, 16'h0, "R1 oe");
        host_read(4'd0, 5, "R1 index");
        host_read(4'd1, 5, "R1 reg0");

        host_write(4'd0, 16'h0003, 1'b0);
        host_read(4'd0, 5, "R2 index load");
        host_read(4'd0, 5, "R2 index no advance");

        host_write(4'd1, 16'hA5A5, 1'b0);
        host_write(4'd1, 16'h1234, 1'b0);
        host_read(4'd0, 5, "R3 index after writes");
        host_write(4'd0, 16'h0003, 1'b0);
        host_read(4'd1, 5, "R4 read reg3");
        host_read(4'd1, 5, "R4 read reg4");
        host_read(4'd0, 5, "R4 index after reads");

        host_write(4'd0, 16'h000F, 1'b0);
        host_write(4'd1, 16'hBEEF, 1'b0);
        host_read(4'd0, 5, "R3 wrap");
        host_write(4'd0, 16'h000F, 1'b0);
        host_read(4'd1, 5, "R4 read reg15");
        host_read(4'd0, 5, "R4 wrap");

        host_write(4'd0, 16'h0003, 1'b0);
        host_read(4'd1, 20, "R6 long pulse data");
        host_read(4'd0, 5, "R6 single advance");

        host_write(4'd0, 16'h0003, 1'b0);
        host_write(4'd1, 16'h0000, 1'b1);
        host_read(4'd0, 5, "R9 index kept");
        host_read(4'd1, 5, "R9 reg kept");

        // R8: read strobe without chip select leaves the bus released
        @(negedge clk); hrd_n = 1'b0;
        #1 check({15'b0, hdoe}, 16'h0, "R8 no cs");
        @(negedge clk); hrd_n = 1'b1;
        repeat (3) @(negedge clk);
        host_read(4'd0, 5, "R9 rd without cs");

        // R7 narrow bus
        bus_wide = 1'b0;
        host_write(4'd0, 16'hFF06, 1'b0);
        host_write(4'd1, 16'hABCD, 1'b0);
        host_write(4'd8, 16'h0006, 1'b0);
        host_read(4'd9, 5, "R7 narrow alias read");
        host_write(4'd0, 16'h0003, 1'b0);
        host_read(4'd1, 5, "R7 narrow upper zero");
        bus_wide = 1'b1;
        host_write(4'd0, 16'h0006, 1'b0);
        host_read(4'd1, 5, "R7 narrow write zero-extended");
        host_write(4'd8, 16'h0002, 1'b0);
        host_read(4'd0, 5, "R7 wide undecoded write");
        host_read(4'd9, 5, "R7 wide undecoded read");
        host_read(4'd0, 5, "R7 undecoded index kept");

        // R11: camera on, internal controller owns the pins
        @(negedge clk);
        cam_en = 1'b1; hcs2_n = 1'b0; haddr = 4'd1; hwr_n = 1'b0; hdin = 16'h1357;
        core_lcd_cs_n = 1'b1; core_lcd_rs = 1'b0; core_lcd_wr_n = 1'b1; core_lcd_data = 16'h2468;
        #1;
        check({13'b0, lcd_cs_n, lcd_rs, lcd_wr_n}, 16'h5, "R11 ctl");
        check(lcd_data, 16'h2468, "R11 data");
        // R10: bypass, host drives the pins
        cam_en = 1'b0;
        #1;
        check({13'b0, lcd_cs_n, lcd_rs, lcd_wr_n}, 16'h2, "R10 ctl");
        check(lcd_data, 16'h1357, "R10 data");
        hcs2_n = 1'b1; haddr = 4'd0; hwr_n = 1'b1; hdin = 16'hC3C3;
        #1;
        check({13'b0, lcd_cs_n, lcd_rs, lcd_wr_n}, 16'h5, "R10 ctl follow");
        check(lcd_data, 16'hC3C3, "R10 data follow");
        cam_en = 1'b1;
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule